// File: doc/BRIEF.md
# March Test Pattern Sequencer

This block steps a memory under test through a fixed march algorithm. It keeps one linear address counter, split into a row field and a column field, and a short down-counting index that selects the element applied at the current address. Each enabled cycle applies one element: a write or a read, with checkerboard data in true or inverted form. A read compares the memory's returned word with the expected pattern. Any mismatch raises a fail pulse, and the location of the first mismatch is kept.

A run is launched by a start pulse while the block is idle. It then advances only in cycles where the cycle-enable strobe is high, so a tester can throttle it to any rate. The first pass walks the addresses upward and applies four elements to each. The second pass visits the addresses in complemented order and applies three elements to each. A single done pulse marks the end of the run.

Top module: `mpat_seq`

## Requirements
- R1: After reset no command is asserted, done and fail are low, and both address outputs and both failing-address outputs are zero.
- R2: A start pulse seen while idle launches a run. The first enabled cycle of the run is an initialisation step with no command. A start pulse during a run has no effect on the sequence.
- R3: The sequence advances only in cycles with cyc_en high. The write and read strobes are asserted only in such cycles. While cyc_en and start are both low, the address outputs hold their value.
- R4: The first pass visits linear addresses {addr_x, addr_y} from 0 upward, with addr_y varying fastest. At each address it applies four elements in this order: write true, read true, write inverted, read inverted. The write and read strobes are never high together.
- R5: Every bit of pat_data equals addr_x[0] XOR addr_y[0] XOR inv, where inv is 1 for the inverted elements. On a write, pat_data is the data written. On a read, it is the value expected.
- R6: The second pass uses counter values 0 upward, and the address outputs show the bitwise complement of the counter. At each address it applies three elements in this order: read inverted, write true, read true.
- R7: When the counter wraps at the end of the second pass, done is high for exactly one cycle, in the cycle after the final element. In that cycle the address outputs are zero and no command is asserted.
- R8: A read whose rdata differs from pat_data sets fail high in the following cycle, for that one cycle only. A read that matches leaves fail low.
- R9: fail_x and fail_y capture the address of the first mismatching read of a run and keep it through later mismatches. An accepted start clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| cyc_en | input | 1 | Applies the current element and advances the sequence |
| cmd_we | output | 1 | Write strobe to the memory under test |
| cmd_re | output | 1 | Read strobe to the memory under test |
| addr_x | output | XW | Row address |
| addr_y | output | YW | Column address |
| pat_data | output | DW | Write data or expected read data |
| rdata | input | DW | Data returned by the memory in the read cycle |
| fail | output | 1 | One-cycle mismatch flag |
| fail_x | output | XW | Row of the first mismatch |
| fail_y | output | YW | Column of the first mismatch |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach from the ports is a fault that the first pass cannot see and only the complemented pass can expose. The bench memory model supplies one: every write to an aggressor word flips one bit of a lower victim word. In the first pass the aggressor is written twice, true then inverted, so the bit flips twice and the flips cancel. The victim has also already been checked by then. In the second pass the aggressor is written once, before the victim is reached, so the first fail and the latched address must point at the victim in the complemented pass. Other runs add gaps in cyc_en, send a start pulse during a run, and inject stuck-at bits at two addresses to check that the latch keeps only the first mismatch.

// File: rtl/mpat_pkg.sv
// Shared types for the march sequencer: controller states, element
// operations and the element decoder used by the top level.
package mpat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INIT = 2'd1,
        ST_FWD  = 2'd2,
        ST_CMP  = 2'd3
    } mpat_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2
    } mpat_op_e;

    typedef struct packed {
        mpat_op_e op;
        logic     inv;
    } mpat_elem_t;

    localparam int FWD_ELEMS = 4;
    localparam int CMP_ELEMS = 3;
    localparam int IDX_W     = $clog2(FWD_ELEMS);

    // Map (state, remaining index) to the element applied at the current address.
    function automatic mpat_elem_t elem_decode(mpat_state_e st, logic [IDX_W-1:0] idx);
        mpat_elem_t el;
        el.op  = OP_NONE;
        el.inv = 1'b0;
        case (st)
            ST_FWD: begin
                case (idx)
                    2'd3:    begin el.op = OP_WR; el.inv = 1'b0; end
                    2'd2:    begin el.op = OP_RD; el.inv = 1'b0; end
                    2'd1:    begin el.op = OP_WR; el.inv = 1'b1; end
                    default: begin el.op = OP_RD; el.inv = 1'b1; end
                endcase
            end
            ST_CMP: begin
                case (idx)
                    2'd2:    begin el.op = OP_RD; el.inv = 1'b1; end
                    2'd1:    begin el.op = OP_WR; el.inv = 1'b0; end
                    default: begin el.op = OP_RD; el.inv = 1'b0; end
                endcase
            end
            default: ;
        endcase
        return el;
    endfunction

endpackage

// File: rtl/mpat_addr_gen.sv
// Linear address counter {row, column}, column in the low bits.
// Assumes clr and step are never high in the same cycle; step wraps to zero.
module mpat_addr_gen #(
    parameter int XW = 16,
    parameter int YW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [XW-1:0] cnt_x,
    output logic [YW-1:0] cnt_y,
    output logic          last
);
    localparam int AW = XW + YW;

    logic [AW-1:0] cnt;

    // Counter: cleared at launch, incremented once per finished address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign cnt_x = cnt[AW-1:YW];
    assign cnt_y = cnt[YW-1:0];
    assign last  = &cnt;

endmodule

// File: rtl/mpat_ctrl.sv
// Microprogram controller: idle, one initialisation step, forward pass,
// complemented pass. A down-counting index selects the element; when it is
// exhausted the address advances, and address wrap ends the pass.
// Assumes addr_last reflects the counter value of the current cycle.
module mpat_ctrl
    import mpat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cyc_en,
    input  logic             addr_last,
    output mpat_state_e      state,
    output logic [IDX_W-1:0] idx,
    output logic             addr_step,
    output logic             launch,
    output logic             done
);
    logic in_pass;

    assign launch    = start && (state == ST_IDLE);
    assign in_pass   = (state == ST_FWD) || (state == ST_CMP);
    assign addr_step = cyc_en && in_pass && (idx == '0);

    // Sequencing of states and the element index; done pulses on final wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) state <= ST_INIT;
                end
                ST_INIT: begin
                    if (cyc_en) begin
                        state <= ST_FWD;
                        idx   <= IDX_W'(FWD_ELEMS - 1);
                    end
                end
                ST_FWD: begin
                    if (cyc_en) begin
                        if (idx != '0) begin
                            idx <= idx - 1'b1;
                        end else if (addr_last) begin
                            state <= ST_CMP;
                            idx   <= IDX_W'(CMP_ELEMS - 1);
                        end else begin
                            idx <= IDX_W'(FWD_ELEMS - 1);
                        end
                    end
                end
                default: begin
                    if (cyc_en) begin
                        if (idx != '0) begin
                            idx <= idx - 1'b1;
                        end else if (addr_last) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                            done  <= 1'b1;
                        end else begin
                            idx <= IDX_W'(CMP_ELEMS - 1);
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/mpat_cmp.sv
// Read comparator: registers a one-cycle fail on any mismatching read and
// holds the address of the first mismatch until the next launch.
// Assumes clr (launch) never coincides with a read.
module mpat_cmp #(
    parameter int XW = 16,
    parameter int YW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          rd_en,
    input  logic [DW-1:0] exp_data,
    input  logic [DW-1:0] rd_data,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    output logic          fail,
    output logic [XW-1:0] first_x,
    output logic [YW-1:0] first_y
);
    logic miss;
    logic seen;

    assign miss = rd_en && (rd_data != exp_data);

    // Fail pulse for each mismatching read.
    always_ff @(posedge clk) begin
        if (!rst_n) fail <= 1'b0;
        else        fail <= miss;
    end

    // First-failure latch, cleared when a new run is launched.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen    <= 1'b0;
            first_x <= '0;
            first_y <= '0;
        end else if (miss && !seen) begin
            seen    <= 1'b1;
            first_x <= cur_x;
            first_y <= cur_y;
        end
    end

endmodule

// File: rtl/mpat_seq.sv
// March pattern sequencer top: joins controller, address counter and
// comparator; decodes the current element into strobes, complements the
// address in the second pass and forms checkerboard data.
// Assumes the memory returns rdata combinationally in the read cycle.
module mpat_seq
    import mpat_pkg::*;
#(
    parameter int XW = 16,
    parameter int YW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cyc_en,
    output logic          cmd_we,
    output logic          cmd_re,
    output logic [XW-1:0] addr_x,
    output logic [YW-1:0] addr_y,
    output logic [DW-1:0] pat_data,
    input  logic [DW-1:0] rdata,
    output logic          fail,
    output logic [XW-1:0] fail_x,
    output logic [YW-1:0] fail_y,
    output logic          done
);
    mpat_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             addr_step;
    logic             launch;
    logic             addr_last;
    logic [XW-1:0]    cnt_x;
    logic [YW-1:0]    cnt_y;
    mpat_elem_t       elem;
    logic             comp_addr;
    logic             pat_bit;

    mpat_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cyc_en    (cyc_en),
        .addr_last (addr_last),
        .state     (state),
        .idx       (idx),
        .addr_step (addr_step),
        .launch    (launch),
        .done      (done)
    );

    mpat_addr_gen #(.XW(XW), .YW(YW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .step  (addr_step),
        .cnt_x (cnt_x),
        .cnt_y (cnt_y),
        .last  (addr_last)
    );

    // Element decode and strobe gating by the cycle-enable strobe.
    always_comb begin
        elem   = elem_decode(state, idx);
        cmd_we = cyc_en && (elem.op == OP_WR);
        cmd_re = cyc_en && (elem.op == OP_RD);
    end

    // Address presentation: complemented during the second pass.
    assign comp_addr = (state == ST_CMP);
    assign addr_x    = comp_addr ? ~cnt_x : cnt_x;
    assign addr_y    = comp_addr ? ~cnt_y : cnt_y;

    // Checkerboard data from address parity and the element's inversion.
    assign pat_bit   = addr_x[0] ^ addr_y[0] ^ elem.inv;
    assign pat_data  = {DW{pat_bit}};

    mpat_cmp #(.XW(XW), .YW(YW), .DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (launch),
        .rd_en    (cmd_re),
        .exp_data (pat_data),
        .rd_data  (rdata),
        .cur_x    (addr_x),
        .cur_y    (addr_y),
        .fail     (fail),
        .first_x  (fail_x),
        .first_y  (fail_y)
    );

endmodule

// File: rtl/mpat_seq_chk.sv
// Port-level protocol checks for mpat_seq, attached with bind.
module mpat_seq_chk #(
    parameter int XW = 16,
    parameter int YW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          cyc_en,
    input logic          cmd_we,
    input logic          cmd_re,
    input logic [XW-1:0] addr_x,
    input logic [YW-1:0] addr_y,
    input logic          fail,
    input logic          done
);
    // R3: no command without the cycle-enable strobe
    p_cmd_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |-> (!cmd_we && !cmd_re));

    // R3: address frozen while neither strobe nor start is present
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !start) |=> ($stable(addr_x) && $stable(addr_y)));

    // R4: write and read never issued together
    p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && cmd_re));

    // R7: done is a single-cycle pulse with the address returned to zero
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (addr_x == '0 && addr_y == '0 && !cmd_we && !cmd_re));

    // R8: a fail pulse is always preceded by a read
    p_fail_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(cmd_re));

endmodule

bind mpat_seq mpat_seq_chk #(.XW(XW), .YW(YW), .DW(DW)) u_chk (.*);

// File: tb/tb_mpat_seq.sv
module tb_mpat_seq;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int DW = 4;
    localparam int NA = 1 << (XW + YW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          cyc_en = 1'b0;
    logic          cmd_we, cmd_re, fail, done;
    logic [XW-1:0] addr_x, fail_x;
    logic [YW-1:0] addr_y, fail_y;
    logic [DW-1:0] pat_data, rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  pend_fail = 0;
    bit  seen = 0;
    int  first_pa = 0;

    // memory model controls
    bit  stk_en = 0;
    int  stk_a0 = 0, stk_a1 = 0;
    bit  cpl_en = 0;
    int  cpl_agg = 0, cpl_vic = 0;
    logic [DW-1:0] mem [NA];

    always #10 clk = ~clk;

    mpat_seq #(.XW(XW), .YW(YW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_en(cyc_en),
        .cmd_we(cmd_we), .cmd_re(cmd_re), .addr_x(addr_x), .addr_y(addr_y),
        .pat_data(pat_data), .rdata(rdata), .fail(fail),
        .fail_x(fail_x), .fail_y(fail_y), .done(done)
    );

    wire [XW+YW-1:0] ma = {addr_x, addr_y};

    // behavioural memory with coupling fault on writes
    always @(posedge clk) begin
        if (cmd_we) begin
            mem[ma] <= pat_data;
            if (cpl_en && int'(ma) == cpl_agg && cpl_agg != cpl_vic)
                mem[cpl_vic] <= mem[cpl_vic] ^ 4'b0001;
        end
    end

    // stuck-at-0 on bit 0 at two addresses
    assign rdata = mem[ma] & ~((stk_en && (int'(ma) == stk_a0 || int'(ma) == stk_a1)) ? 4'b0001 : 4'b0000);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick_idle(input bit st);
        @(negedge clk);
        cyc_en = 1'b0;
        start  = st;
        #1;
        chk(fail == pend_fail, "R8 fail pulse", fail, pend_fail);
        pend_fail = 0;
        chk(!cmd_we && !cmd_re, "R3 no command when idle strobe", {cmd_we, cmd_re}, 0);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
    endtask

    // op: 0 none, 1 write, 2 read
    task automatic tick_step(input int op, input int pa, input bit inv, input string req);
        logic [DW-1:0] expd;
        bit par;
        @(negedge clk);
        cyc_en = 1'b1;
        #1;
        chk(fail == pend_fail, "R8 fail pulse", fail, pend_fail);
        pend_fail = 0;
        chk(cmd_we == (op == 1) && cmd_re == (op == 2), req, {cmd_we, cmd_re}, op);
        if (op != 0) begin
            chk(int'({addr_x, addr_y}) == pa, req, int'({addr_x, addr_y}), pa);
            par  = pa[YW] ^ pa[0] ^ inv;
            expd = {DW{par}};
            chk(pat_data == expd, "R5 checkerboard data", pat_data, expd);
            if (op == 2 && rdata != expd) begin
                pend_fail = 1;
                if (!seen) begin
                    seen = 1;
                    first_pa = pa;
                end
            end
        end
    endtask

    task automatic run_march(input bit gaps, input bit mid_start);
        int k = 0;
        seen = 0;
        @(negedge clk);
        start  = 1'b1;
        cyc_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(fail_x == 0 && fail_y == 0, "R9 latch cleared at launch", {fail_x, fail_y}, 0);
        tick_step(0, 0, 0, "R2 initialisation step");
        for (int a = 0; a < NA; a++) begin
            for (int e = 0; e < 4; e++) begin
                if (gaps && (k % 3) == 2) begin
                    @(negedge clk);
                    cyc_en = 1'b0;
                    start  = mid_start && (k == 200);
                    #1;
                    chk(fail == pend_fail, "R8 fail pulse", fail, pend_fail);
                    pend_fail = 0;
                    chk(!cmd_we && !cmd_re, "R3 gap cycle", {cmd_we, cmd_re}, 0);
                    @(negedge clk);
                    start = 1'b0;
                    cyc_en = 1'b0;
                    #1;
                    chk(!cmd_we && !cmd_re, "R2 start during run ignored", {cmd_we, cmd_re}, 0);
                end
                k++;
                tick_step((e % 2 == 0) ? 1 : 2, a, e >= 2, "R4 forward element");
            end
        end
        for (int a = 0; a < NA; a++) begin
            for (int e = 0; e < 3; e++) begin
                if (gaps && (k % 3) == 2) begin
                    @(negedge clk);
                    cyc_en = 1'b0;
                    #1;
                    chk(fail == pend_fail, "R8 fail pulse", fail, pend_fail);
                    pend_fail = 0;
                    chk(!cmd_we && !cmd_re, "R3 gap cycle", {cmd_we, cmd_re}, 0);
                end
                k++;
                tick_step((e == 1) ? 1 : 2, (NA - 1) - a, e == 0, "R6 complemented element");
            end
        end
        @(negedge clk);
        cyc_en = 1'b0;
        #1;
        chk(fail == pend_fail, "R8 fail pulse", fail, pend_fail);
        pend_fail = 0;
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(addr_x == 0 && addr_y == 0, "R7 address cleared", {addr_x, addr_y}, 0);
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        chk(!cmd_we && !cmd_re, "R7 stopped", {cmd_we, cmd_re}, 0);
        if (seen)
            chk(int'({fail_x, fail_y}) == first_pa, "R9 first failing address", int'({fail_x, fail_y}), first_pa);
        else
            chk(fail_x == 0 && fail_y == 0, "R9 no failure latched", {fail_x, fail_y}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!cmd_we && !cmd_re, "R1 reset strobes", {cmd_we, cmd_re}, 0);
        chk(!done && !fail, "R1 reset flags", {done, fail}, 0);
        chk(addr_x == 0 && addr_y == 0, "R1 reset address", {addr_x, addr_y}, 0);
        chk(fail_x == 0 && fail_y == 0, "R1 reset fail address", {fail_x, fail_y}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // clean run, strobe every cycle
        run_march(0, 0);
        chk(!seen, "R8 clean run has no mismatch", seen, 0);

        // clean run with gaps and a start pulse mid-run
        run_march(1, 1);

        // stuck-at bits at two addresses: first one must stay latched
        stk_en = 1; stk_a0 = 9; stk_a1 = 50;
        run_march(0, 0);
        chk(seen && first_pa == 9, "R9 first of two stuck faults", first_pa, 9);

        // coupling fault visible only in the complemented pass
        stk_en = 0;
        cpl_en = 1; cpl_agg = 40; cpl_vic = 5;
        run_march(1, 0);
        chk(seen && first_pa == 5, "R6 coupling fault found in second pass", first_pa, 5);
        chk(int'({fail_x, fail_y}) == 5, "R9 latched victim address", int'({fail_x, fail_y}), 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule